// File: doc/BRIEF.md
# Splittable Event Counter Bank

This block holds four physical event counters behind a small register port. Each counter either runs as one 32-bit counter or is cut in half at run time into two 16-bit counters, so software sees eight logical counters. Counter writes from software never touch a running counter directly. They go into a holding latch for that physical counter and reach the live counter only when the control register is written with its enable bit set.

A wrap from all-ones to zero raises a per-logical-counter status bit. An interrupt line is raised when a status bit and its mask bit are both set. Reading the status register returns the pending bits and clears them in the same access. Writing the status register loads the mask. Registers are 32 bits wide and travel in the upper half of a 64-bit bus word.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset all four physical counters run in 32-bit mode. In that mode logical index l and l+4 both address physical counter l, and reads and writes carry the full 32-bit value.
- R2: Control bit 1+p set splits physical counter p. Logical p is then the upper 16 bits and logical p+4 the lower 16 bits. The halves count and wrap independently, with no carry between them, and reads return the half zero-extended.
- R3: A counter write goes into a holding latch and leaves the live counter unchanged. A control write with the enable bit clear commits nothing. In split mode a half write keeps the other half from the pending latch, or from the live counter when nothing is pending.
- R4: A control write with bit 0 (enable) set copies every pending latch into its live counter. This also happens when the monitor is already enabled.
- R5: While enabled, a 32-bit counter or an upper half p adds one on each cycle that evt[p] is high. A lower half p adds one on each cycle that evt[p+4] is high.
- R6: While the enable bit is clear, no counter changes except by commit.
- R7: A wrap of a 32-bit counter or an upper half p sets status bit p. A wrap of a lower half p sets status bit p+4. A read of the status register (address 9) returns the pending bits and clears them.
- R8: A write to address 9 loads the 8-bit interrupt mask from the low data bits. irq is high exactly when some status bit and its mask bit are both set, so a zero mask holds irq low.
- R9: A wrap in the same cycle as a status-clearing read is absent from the returned value and stays pending afterwards.
- R10: Addresses 0–7 are the logical counters, 8 is control and 9 is status. Write data is taken from bits 63:32. Read data appears one cycle after the request, with rvalid set, in bits 63:32 with bits 31:0 zero. Other addresses read zero.
- R11: Reset clears every counter, latch, control, status and mask register and holds irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Register access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register address |
| wdata | input | 64 | Write data, register value in bits 63:32 |
| evt | input | 8 | Event inputs, one per logical counter |
| rvalid | output | 1 | Read data valid, one cycle after a read |
| rdata | output | 64 | Read data, register value in bits 63:32 |
| irq | output | 1 | Interrupt, status AND mask |

## Verification
The bench sweeps every logical counter in both modes with arithmetically generated values. A design that mixed up which half belongs to logical p and which to p+4, or that failed to alias logical p+4 onto physical p in 32-bit mode, gives the wrong readback. It drives a half-counter through its wrap to show that no carry leaks into the other half and that the correct status bit rises. It writes counters while the monitor is disabled and while it is running, so a design that committed eagerly, or that skipped the re-commit on a repeated enable write, shows a stale or premature value. The bench also lines up a wrap exactly on the edge of a status-clearing read. A design that clears before merging new overflows loses that bit.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_SPLIT_LSB = 1;

  typedef enum logic [1:0] {
    SEL_CTR,
    SEL_CTRL,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             split,
  input  logic             commit,
  input  logic             wr,
  input  logic             wr_hi,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             evt_hi,
  input  logic             evt_lo,
  output logic [CNT_W-1:0] live,
  output logic             pending,
  output logic             ovf_hi,
  output logic             ovf_lo
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] live_q, latch_q, live_d, latch_d, base;
  logic             pend_q, load;
  logic [HALF_W-1:0] hi_q, lo_q;

  assign hi_q = live_q[CNT_W-1:HALF_W];
  assign lo_q = live_q[HALF_W-1:0];

  always_comb begin
    load   = commit & pend_q;
    base   = pend_q ? latch_q : live_q;
    ovf_hi = !load && en && evt_hi && (split ? (&hi_q) : (&live_q));
    ovf_lo = !load && en && split && evt_lo && (&lo_q);

    live_d = live_q;
    if (load) begin
      live_d = latch_q;
    end else if (en) begin
      if (split) begin
        live_d = {hi_q + HALF_W'(evt_hi), lo_q + HALF_W'(evt_lo)};
      end else begin
        live_d = live_q + CNT_W'(evt_hi);
      end
    end

    latch_d = latch_q;
    if (wr) begin
      if (!split) begin
        latch_d = wr_val;
      end else if (wr_hi) begin
        latch_d = {wr_val[HALF_W-1:0], base[HALF_W-1:0]};
      end else begin
        latch_d = {base[CNT_W-1:HALF_W], wr_val[HALF_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      live_q  <= live_d;
      latch_q <= latch_d;
      if (wr) begin
        pend_q <= 1'b1;
      end else if (commit) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign live    = live_q;
  assign pending = pend_q;
endmodule

// File: rtl/evt_ctr_irq.sv
module evt_ctr_irq #(
  parameter int NUM_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BITS-1:0] ovf,
  input  logic                clr,
  input  logic                mask_wr,
  input  logic [NUM_BITS-1:0] mask_val,
  output logic [NUM_BITS-1:0] status,
  output logic [NUM_BITS-1:0] mask,
  output logic                irq
);
  logic [NUM_BITS-1:0] status_q, status_d, mask_q, mask_d;
  logic                irq_q;

  always_comb begin
    status_d = (clr ? '0 : status_q) | ovf;
    mask_d   = mask_wr ? mask_val : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= |(status_d & mask_d);
    end
  end

  assign status = status_q;
  assign mask   = mask_q;
  assign irq    = irq_q;
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int NUM_PHYS = 4,
  parameter int CNT_W    = 32,
  parameter int BUS_W    = 64,
  parameter int ADDR_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BUS_W-1:0]      wdata,
  input  logic [2*NUM_PHYS-1:0] evt,
  output logic                  rvalid,
  output logic [BUS_W-1:0]      rdata,
  output logic                  irq
);
  localparam int NUM_LOG   = 2 * NUM_PHYS;
  localparam int REG_W     = BUS_W / 2;
  localparam int HALF_W    = CNT_W / 2;
  localparam int PIDX_W    = $clog2(NUM_PHYS);
  localparam int ADDR_CTRL = NUM_LOG;
  localparam int ADDR_STAT = NUM_LOG + 1;

  logic [REG_W-1:0]                 wval, ctrl_q, rd_val;
  logic                             unused_lo;
  reg_sel_e                         sel;
  logic [PIDX_W-1:0]                pidx;
  logic                             is_hi, commit, stat_rd, mask_wr, en_q;
  logic [NUM_PHYS-1:0]              ctr_wr, split, pending;
  logic [NUM_PHYS-1:0][CNT_W-1:0]   live;
  logic [NUM_LOG-1:0]               ovf, status_q, mask_q;
  logic                             rvalid_q;
  logic [BUS_W-1:0]                 rdata_q;

  assign wval      = wdata[BUS_W-1:REG_W];
  assign unused_lo = ^wdata[REG_W-1:0];
  assign pidx      = addr[PIDX_W-1:0];
  assign is_hi     = !addr[PIDX_W];
  assign en_q      = ctrl_q[CTRL_EN_BIT];

  always_comb begin
    if (addr < ADDR_W'(NUM_LOG))        sel = SEL_CTR;
    else if (addr == ADDR_W'(ADDR_CTRL)) sel = SEL_CTRL;
    else if (addr == ADDR_W'(ADDR_STAT)) sel = SEL_STAT;
    else                                 sel = SEL_NONE;
  end

  assign commit  = req && we && (sel == SEL_CTRL) && wval[CTRL_EN_BIT];
  assign stat_rd = req && !we && (sel == SEL_STAT);
  assign mask_wr = req && we && (sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (req && we && (sel == SEL_CTRL)) begin
      ctrl_q <= wval;
    end
  end

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_slice
    assign split[p]  = ctrl_q[CTRL_SPLIT_LSB + p];
    assign ctr_wr[p] = req && we && (sel == SEL_CTR) && (pidx == PIDX_W'(p));

    evt_ctr_slice #(.CNT_W(CNT_W)) u_slice (
      .clk     (clk),
      .rst     (rst),
      .en      (en_q),
      .split   (split[p]),
      .commit  (commit),
      .wr      (ctr_wr[p]),
      .wr_hi   (is_hi),
      .wr_val  (CNT_W'(wval)),
      .evt_hi  (evt[p]),
      .evt_lo  (evt[p + NUM_PHYS]),
      .live    (live[p]),
      .pending (pending[p]),
      .ovf_hi  (ovf[p]),
      .ovf_lo  (ovf[p + NUM_PHYS])
    );
  end

  evt_ctr_irq #(.NUM_BITS(NUM_LOG)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .ovf      (ovf),
    .clr      (stat_rd),
    .mask_wr  (mask_wr),
    .mask_val (wval[NUM_LOG-1:0]),
    .status   (status_q),
    .mask     (mask_q),
    .irq      (irq)
  );

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_CTR: begin
        if (split[pidx]) begin
          rd_val = is_hi ? REG_W'(live[pidx][CNT_W-1:HALF_W])
                         : REG_W'(live[pidx][HALF_W-1:0]);
        end else begin
          rd_val = REG_W'(live[pidx]);
        end
      end
      SEL_CTRL: rd_val = ctrl_q;
      SEL_STAT: rd_val = REG_W'(status_q);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req && !we;
      rdata_q  <= (req && !we) ? {rd_val, {REG_W{1'b0}}} : '0;
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk #(
  parameter int NUM_PHYS = 4,
  parameter int CNT_W    = 32,
  parameter int BUS_W    = 64,
  parameter int ADDR_W   = 4
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              req,
  input logic                              we,
  input logic [ADDR_W-1:0]                 addr,
  input logic                              rvalid,
  input logic [BUS_W-1:0]                  rdata,
  input logic                              irq,
  input logic                              en_q,
  input logic                              commit,
  input logic                              stat_rd,
  input logic [NUM_PHYS-1:0]               pending,
  input logic [NUM_PHYS-1:0][CNT_W-1:0]    live,
  input logic [2*NUM_PHYS-1:0]             status_q,
  input logic [2*NUM_PHYS-1:0]             mask_q
);
  localparam int NUM_LOG = 2 * NUM_PHYS;
  localparam int REG_W   = BUS_W / 2;

  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    (req && !we) |=> rvalid);

  p_rdata_low_r10: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (rdata[REG_W-1:0] == '0));

  p_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (req && we && (addr < ADDR_W'(NUM_LOG))) |=> (pending != '0));

  p_commit_r4: assert property (@(posedge clk) disable iff (rst)
    commit |=> (pending == '0));

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !commit) |=> $stable(live));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq);
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(
  .NUM_PHYS(NUM_PHYS), .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .we       (we),
  .addr     (addr),
  .rvalid   (rvalid),
  .rdata    (rdata),
  .irq      (irq),
  .en_q     (en_q),
  .commit   (commit),
  .stat_rd  (stat_rd),
  .pending  (pending),
  .live     (live),
  .status_q (status_q),
  .mask_q   (mask_q)
);

// File: tb/sim_evt_ctr_bank.sv
module sim_evt_ctr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [7:0]  evt = '0;
  logic        rvalid;
  logic [63:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  evt_ctr_bank u0 (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .evt(evt), .rvalid(rvalid), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] v);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 4'(a); wdata = {v, 32'hDEAD_BEEF};
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] v);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 4'(a);
    @(negedge clk);
    req = 1'b0;
    chk("R10 rvalid", {31'b0, rvalid}, 32'd1);
    chk("R10 low half zero", rdata[31:0], 32'd0);
    v = rdata[63:32];
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input int idx, input int n);
    @(negedge clk);
    evt[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt[idx] = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 irq", {31'b0, irq}, 32'd0);
    for (int l = 0; l < 8; l++) rd_chk("R11 counter", l, 32'd0);
    rd_chk("R11 control", 8, 32'd0);
    rd_chk("R11 status", 9, 32'd0);
    rd_chk("R10 unmapped", 12, 32'd0);

    // R3 latch only, no commit while enable clear
    bus_wr(0, 32'h0000_0100);
    rd_chk("R3 live unchanged", 0, 32'd0);
    bus_wr(8, 32'h0);
    rd_chk("R3 no commit when enable clear", 0, 32'd0);

    // R4 commit on enable
    bus_wr(8, 32'h1);
    rd_chk("R4 commit", 0, 32'h100);

    // R5 counting
    pulse(0, 7);
    rd_chk("R5 count 32-bit", 0, 32'h107);

    // R6 disabled stops counting
    bus_wr(8, 32'h0);
    pulse(0, 5);
    rd_chk("R6 frozen", 0, 32'h107);

    // R4 re-commit while enabled
    bus_wr(8, 32'h1);
    bus_wr(0, 32'h55);
    rd_chk("R3 write while enabled latched", 0, 32'h107);
    bus_wr(8, 32'h1);
    rd_chk("R4 recommit", 0, 32'h55);

    // R2 split sweep over all logical counters
    bus_wr(8, 32'h1F);
    for (int l = 0; l < 8; l++) bus_wr(l, {16'hABCD, 16'h1000 + 16'(l) * 16'h0123});
    bus_wr(8, 32'h1F);
    for (int l = 0; l < 8; l++)
      rd_chk("R2 split readback", l, {16'h0, 16'h1000 + 16'(l) * 16'h0123});

    // R1 32-bit sweep, writes via alias index for even counters
    bus_wr(8, 32'h1);
    for (int p = 0; p < 4; p++)
      bus_wr((p % 2 == 0) ? p + 4 : p, 32'h9000_0000 + 32'(p) * 32'h0102_0304);
    bus_wr(8, 32'h1);
    for (int p = 0; p < 4; p++) begin
      rd_chk("R1 32-bit readback", p, 32'h9000_0000 + 32'(p) * 32'h0102_0304);
      rd_chk("R1 alias readback", p + 4, 32'h9000_0000 + 32'(p) * 32'h0102_0304);
    end
    rd_chk("R7 no status yet", 9, 32'h0);

    // R2/R3 split half merge, independent wrap, R5 lower-half events
    bus_wr(8, 32'h5);
    bus_wr(1, 32'h0000_FFFE);
    bus_wr(5, 32'h0000_0003);
    bus_wr(8, 32'h5);
    rd_chk("R3 merged upper", 1, 32'hFFFE);
    rd_chk("R3 merged lower", 5, 32'h0003);
    pulse(1, 3);
    rd_chk("R2 upper wrapped", 1, 32'h0001);
    rd_chk("R2 lower no carry", 5, 32'h0003);
    pulse(5, 2);
    rd_chk("R5 lower counts", 5, 32'h0005);
    rd_chk("R2 upper untouched", 1, 32'h0001);

    // R8 mask and irq
    chk("R8 irq masked off", {31'b0, irq}, 32'd0);
    bus_wr(9, 32'h0000_0002);
    chk("R8 irq on", {31'b0, irq}, 32'd1);
    bus_wr(9, 32'h0);
    chk("R8 zero mask", {31'b0, irq}, 32'd0);
    bus_wr(9, 32'h0000_0002);
    chk("R8 irq on again", {31'b0, irq}, 32'd1);

    // R7 read clears
    rd_chk("R7 status upper-half wrap", 9, 32'h02);
    chk("R8 irq drops after clear", {31'b0, irq}, 32'd0);
    rd_chk("R7 status cleared", 9, 32'h0);

    // R1/R7 32-bit wrap
    bus_wr(8, 32'h1);
    bus_wr(2, 32'hFFFF_FFFF);
    bus_wr(7, 32'hFFFF_FFFF);
    bus_wr(8, 32'h1);
    pulse(2, 1);
    rd_chk("R1 32-bit wrap", 2, 32'h0);
    rd_chk("R7 status 32-bit wrap", 9, 32'h04);

    // R9 wrap on the same edge as a clearing read
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 4'd9; evt[3] = 1'b1;
    @(negedge clk);
    req = 1'b0; evt[3] = 1'b0;
    chk("R9 returned without new wrap", rdata[63:32], 32'h0);
    rd_chk("R9 wrap kept pending", 9, 32'h08);
    rd_chk("R1 alias after wrap", 7, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule